// File: doc/BRIEF.md
# Workload-Driven Regulator Mode Governor

This block chooses the supply mode of an integrated switched-capacitor regulator with no software in the loop. Upstream logic counts regulator switching events over a fixed window. Each window's count stands for the core power in that window and reaches the governor as a one-cycle sample strobe. The governor tracks whether the supply is at its configured "fast" mode or its configured "slow" mode. The action a sample can trigger depends on that level. A sample below the low threshold can only move the supply down from fast, and a sample above the high threshold can only move it up from slow. This gives hysteretic, mode-aware decisions.

Every move is followed by a settling rule. The sample right after a move is discarded, because its window straddled the transition. A programmable dwell also keeps the level fixed for a minimum number of samples. An enable input can suspend the automatic loop. A separate override input can force any mode code onto the regulator.

The decision takes one clock from the sampled count to the new mode code, so at 125 MHz it finishes in 8 ns, well below the microsecond budget.

Top module: `vmode_governor`

## Requirements
- R1: After reset, the level is fast, `mode_sel` equals `cfg_hi_mode` and `mode_chg` is 0. Mode codes are 2 bits: 00 = 1.0 V, 01 = 0.9 V, 10 = 0.67 V, 11 = 0.5 V.
- R2: At the fast level, an eligible sample whose count is strictly below `thr_low` moves the level to slow. A count equal to `thr_low` does not.
- R3: At the slow level, an eligible sample whose count is strictly above `thr_high` moves the level to fast. A count equal to `thr_high` does not.
- R4: A high count at the fast level has no effect, and a low count at the slow level has no effect. The level only changes in response to a sample strobe.
- R5: After a level change, the first max(`dwell_min`, 1) accepted samples are not acted on. The sample after them is evaluated normally.
- R6: A level change shows on `mode_sel` in the cycle after the sample strobe, together with a `mode_chg` pulse that lasts exactly one cycle.
- R7: While `auto_en` is 0, samples are dropped. The level is held and dropped samples do not count toward the dwell.
- R8: While `ovr_en` is 1, `mode_sel` equals `ovr_mode`, samples are dropped and `mode_chg` stays 0. When `ovr_en` is released, `mode_sel` returns to the code of the held level.
- R9: `mode_sel` follows the configured code of the current level at all times. Editing `cfg_hi_mode` or `cfg_lo_mode` changes the output without a `mode_chg` pulse.
- R10: The first sample after reset is eligible immediately. No dwell applies before the first change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking a new power sample |
| sample_count | input | CNT_W | Switching-event count of the finished window |
| thr_low | input | CNT_W | Step-down threshold applied at the fast level |
| thr_high | input | CNT_W | Step-up threshold applied at the slow level |
| cfg_hi_mode | input | 2 | Mode code used at the fast level |
| cfg_lo_mode | input | 2 | Mode code used at the slow level |
| dwell_min | input | AGE_W | Minimum samples between level changes |
| auto_en | input | 1 | Enables automatic decisions |
| ovr_en | input | 1 | Forces `ovr_mode` and suspends decisions |
| ovr_mode | input | 2 | Forced mode code |
| mode_sel | output | 2 | Mode code sent to the regulator |
| mode_chg | output | 1 | One-cycle pulse on each automatic level change |

## Verification
The bench builds the governor with its default 16-bit counts, an 8-bit dwell counter and strict comparisons. It sets the thresholds to 100 and 200, which puts both equality boundaries within reach. It runs with `dwell_min` at 2 and later at 0. Those two settings separate the dwell rule from the rule that always discards the first sample after a change. A second reset shows that the dwell counter starts saturated, and a disabled period shows that dropped samples leave the dwell count unchanged.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
   localparam int MODE_W = 2;
   typedef logic [MODE_W-1:0] mode_t;
   typedef enum logic {
      LVL_FAST = 1'b0,
      LVL_SLOW = 1'b1
   } lvl_e;
endpackage

// File: rtl/vmode_thresh.sv
module vmode_thresh #(
   parameter int CNT_W  = 16,
   parameter bit STRICT = 1'b1
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thr_low,
   input  logic [CNT_W-1:0] thr_high,
   output logic             is_quiet,
   output logic             is_busy
);
   if (CNT_W < 2) begin : g_bad_width
      $error("vmode_thresh: CNT_W must be at least 2");
   end

   if (STRICT) begin : g_strict
      assign is_quiet = count < thr_low;
      assign is_busy  = count > thr_high;
   end else begin : g_inclusive
      assign is_quiet = count <= thr_low;
      assign is_busy  = count >= thr_high;
   end
endmodule

// File: rtl/vmode_dwell.sv
module vmode_dwell #(
   parameter int AGE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [AGE_W-1:0] dwell_min,
   output logic             eligible
);
   localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

   if (AGE_W < 1 || AGE_W > 24) begin : g_bad_age
      $error("vmode_dwell: AGE_W out of range");
   end

   logic [AGE_W-1:0] age_q;

   // age counts accepted samples since the last change, saturating;
   // it starts saturated so the first sample after reset is usable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q <= AGE_MAX;
      end else if (restart) begin
         age_q <= '0;
      end else if (tick && age_q != AGE_MAX) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign eligible = (age_q != '0) && (age_q >= dwell_min);

   // R5: a change is never followed directly by a usable sample
   a_r5_fresh_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !eligible);
endmodule

// File: rtl/vmode_governor.sv
module vmode_governor
   import vmode_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int AGE_W  = 8,
   parameter bit STRICT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_valid,
   input  logic [CNT_W-1:0] sample_count,
   input  logic [CNT_W-1:0] thr_low,
   input  logic [CNT_W-1:0] thr_high,
   input  logic [1:0]       cfg_hi_mode,
   input  logic [1:0]       cfg_lo_mode,
   input  logic [AGE_W-1:0] dwell_min,
   input  logic             auto_en,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_mode,
   output logic [1:0]       mode_sel,
   output logic             mode_chg
);
   if (MODE_W != 2) begin : g_bad_mode
      $error("vmode_governor: mode code must be 2 bits");
   end

   lvl_e level_q;
   logic chg_q;
   logic quiet, busy, eligible, accept, want_flip, flip;

   vmode_thresh #(.CNT_W(CNT_W), .STRICT(STRICT)) i_thresh (
      .count    (sample_count),
      .thr_low  (thr_low),
      .thr_high (thr_high),
      .is_quiet (quiet),
      .is_busy  (busy)
   );

   assign accept    = sample_valid && auto_en && !ovr_en;
   assign want_flip = (level_q == LVL_FAST) ? quiet : busy;
   assign flip      = accept && eligible && want_flip;

   vmode_dwell #(.AGE_W(AGE_W)) i_dwell (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (accept),
      .restart   (flip),
      .dwell_min (dwell_min),
      .eligible  (eligible)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_FAST;
         chg_q   <= 1'b0;
      end else begin
         chg_q <= flip;
         if (flip) begin
            level_q <= (level_q == LVL_FAST) ? LVL_SLOW : LVL_FAST;
         end
      end
   end

   always_comb begin
      if (ovr_en)                   mode_sel = ovr_mode;
      else if (level_q == LVL_FAST) mode_sel = cfg_hi_mode;
      else                          mode_sel = cfg_lo_mode;
   end

   assign mode_chg = chg_q;

   // R4: a change is always answering a sample strobe
   a_r4_change_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> $past(sample_valid));
   // R6: the event is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> !mode_chg);
   // R7: no decisions while the loop is off or overridden
   a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en || ovr_en) |=> $stable(level_q));
   // R8: override suppresses change events
   a_r8_quiet_under_override: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en |=> !mode_chg);
endmodule

// File: tb/test_vmode_governor.sv
module test_vmode_governor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [15:0] smp_cnt = '0;
   logic [15:0] thr_lo = 16'd100;
   logic [15:0] thr_hi = 16'd200;
   logic [1:0]  hi_code = 2'b00;
   logic [1:0]  lo_code = 2'b10;
   logic [7:0]  dwell = 8'd2;
   logic        auto_en = 1'b1;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_code = 2'b01;
   logic [1:0]  mode;
   logic        chg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   vmode_governor i_vmode_governor (
      .clk(clk), .rst_n(rst_n), .sample_valid(smp_vld), .sample_count(smp_cnt),
      .thr_low(thr_lo), .thr_high(thr_hi), .cfg_hi_mode(hi_code), .cfg_lo_mode(lo_code),
      .dwell_min(dwell), .auto_en(auto_en), .ovr_en(ovr_en), .ovr_mode(ovr_code),
      .mode_sel(mode), .mode_chg(chg)
   );

   typedef struct packed {
      logic [15:0] cnt;
      logic [1:0]  mode;
      logic        chg;
      logic [3:0]  req;
   } vec_t;

   // thresholds 100/200, dwell 2, fast code 00, slow code 10
   localparam vec_t VECS [11] = '{
      '{16'd150, 2'b00, 1'b0, 4'd4},  // R4 mid count at fast level
      '{16'd100, 2'b00, 1'b0, 4'd2},  // R2 equal to low threshold
      '{16'd99,  2'b10, 1'b1, 4'd2},  // R2 step down
      '{16'd10,  2'b10, 1'b0, 4'd5},  // R5 first sample discarded
      '{16'd250, 2'b10, 1'b0, 4'd5},  // R5 still inside dwell
      '{16'd50,  2'b10, 1'b0, 4'd4},  // R4 low count at slow level
      '{16'd200, 2'b10, 1'b0, 4'd3},  // R3 equal to high threshold
      '{16'd201, 2'b00, 1'b1, 4'd3},  // R3 step up
      '{16'd0,   2'b00, 1'b0, 4'd5},  // R5 discarded
      '{16'd0,   2'b00, 1'b0, 4'd5},  // R5 dwell
      '{16'd0,   2'b10, 1'b1, 4'd5}   // R5 first usable sample
   };

   task automatic check(input string tag, input logic [1:0] exp_m, input logic exp_c);
      checks++;
      if (mode !== exp_m || chg !== exp_c) begin
         fails++;
         $display("FAIL %s: mode_sel=%b mode_chg=%b expected mode_sel=%b mode_chg=%b",
                  tag, mode, chg, exp_m, exp_c);
      end
   endtask

   task automatic send(input logic [15:0] c);
      @(negedge clk);
      smp_vld = 1'b1;
      smp_cnt = c;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic idle_check(input logic [1:0] exp_m);
      @(negedge clk);
      check("R6 idle cycle", exp_m, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R6 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", 2'b00, 1'b0);

      foreach (VECS[i]) begin
         send(VECS[i].cnt);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].mode, VECS[i].chg);
         idle_check(VECS[i].mode);
      end

      // R9: field edit seen at once, no event
      lo_code = 2'b11;
      #1 check("R9 slow code edit", 2'b11, 1'b0);
      lo_code = 2'b10;
      #1 check("R9 slow code restore", 2'b10, 1'b0);

      // R7: disabled samples dropped and not counted (age 0 here)
      auto_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         send(16'd300);
         check("R7 disabled sample dropped", 2'b10, 1'b0);
      end
      auto_en = 1'b1;
      send(16'd300);
      check("R7 dwell not advanced (discard)", 2'b10, 1'b0);
      send(16'd300);
      check("R7 dwell not advanced (dwell)", 2'b10, 1'b0);
      send(16'd300);
      check("R7 resumes after dwell", 2'b00, 1'b1);

      // R8: override
      @(negedge clk);
      ovr_en = 1'b1;
      #1 check("R8 forced code", 2'b01, 1'b0);
      for (int k = 0; k < 3; k++) begin
         send(16'd0);
         check("R8 sample dropped", 2'b01, 1'b0);
      end
      ovr_en = 1'b0;
      #1 check("R8 release returns to fast code", 2'b00, 1'b0);

      // R1 / R10: fresh reset, first sample usable
      do_reset();
      #1 check("R1 reset after run", 2'b00, 1'b0);
      send(16'd5);
      check("R10 first sample acted on", 2'b10, 1'b1);

      // R5 with zero dwell: discard still applies
      dwell = 8'd0;
      send(16'd500);
      check("R5 zero dwell still discards", 2'b10, 1'b0);
      send(16'd500);
      check("R5 zero dwell next sample", 2'b00, 1'b1);
      idle_check(2'b00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule